// File: doc/BRIEF.md
# Command-Pointer Register Slave for I2C and SMBus Block Transfers

This block is the transaction layer of a serial slave. A bit-level engine in front of it decodes the bus and hands it single-cycle events: start (which also covers a repeated start), stop, an address byte with its direction bit, a received data byte, a request for the next byte to transmit, and a master NACK. The block answers each address or data byte with an acknowledge decision. For each transmit request it supplies the byte to send. It also keeps a 16-entry byte register map that it reaches through a pointer.

The first byte written after the address is a command byte. Bits 3:0 load the pointer and bit 4 selects block mode; the other bits are ignored. In streaming mode, writes and reads run from the pointer until the master stops, and the pointer moves on after each byte, wrapping from Fh to 0h. In block mode, a write takes a count byte and then exactly that many data bytes. A read first sends a count and then that many bytes.

A combined read sets the pointer in a write phase, issues a repeated start, then reads. The pointer and the mode survive the repeated start.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, the timing byte (index 1h) holds 02h and every other writable byte holds 00h, and neither the acknowledge strobe nor the transmit strobe is active.
- R2: After a start, an address byte whose upper seven bits equal `own_addr_i` is acknowledged. Any other address is NACKed, and all data bytes and transmit requests that follow are ignored until the next start.
- R3: The first byte written after a matching write address is acknowledged. Its bits 3:0 load the register pointer and its bit 4 selects block mode (1) or streaming mode (0).
- R4: In streaming mode, each written data byte is acknowledged and stored at the pointer, and then the pointer increments, wrapping from Fh to 0h.
- R5: In block mode, the byte after the command is a count N. Exactly N data bytes are then acknowledged and stored with auto-increment. Further bytes are NACKed and not stored.
- R6: In streaming mode, a read returns the byte at the pointer for each transmit request and increments the pointer, wrapping from Fh to 0h.
- R7: In block mode, a read first returns the count BLK_RD_CNT (default 2), then that many register bytes, then FFh for every later request without moving the pointer.
- R8: Only indices 0h–6h are writable (control, timing, low threshold low/high bytes, high threshold low/high bytes, interrupt control). Writes to 7h–Fh are acknowledged and have no effect. Index Ah reads the ID parameter (default 50h). Ch/Dh read the low/high bytes of `ch0_i`, and Eh/Fh read the low/high bytes of `ch1_i`. Indices 7h, 8h, 9h and Bh read 00h.
- R9: A master NACK ends the read, so later transmit requests get no transmit strobe until the next start.
- R10: A stop or a start in the middle of a block write ends it. Bytes already stored stay stored, and data bytes that arrive before the next address phase are neither acknowledged nor stored. The pointer and mode are kept across a repeated start.
- R11: `ack_vld_o` pulses exactly one cycle after an address or data byte that is accepted for a decision. `tx_vld_o` pulses exactly one cycle after a serviced transmit request. The two strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 7 | Slave address of this device |
| start_i | input | 1 | Start or repeated start event |
| stop_i | input | 1 | Stop event |
| addr_vld_i | input | 1 | Address byte received |
| addr_i | input | 8 | Address byte: bits 7:1 address, bit 0 read (1) / write (0) |
| wr_vld_i | input | 1 | Data byte received from master |
| wr_data_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Engine requests next byte to transmit |
| mnack_i | input | 1 | Master NACKed the last transmitted byte |
| ch0_i | input | 16 | Data channel 0 value |
| ch1_i | input | 16 | Data channel 1 value |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_vld_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Byte to transmit |
| ctrl_o | output | 8 | Control register |
| timing_o | output | 8 | Timing register |
| thr_low_o | output | 16 | Low interrupt threshold |
| thr_high_o | output | 16 | High interrupt threshold |
| int_ctrl_o | output | 8 | Interrupt control register |

## Verification
The assertions cover the strobe discipline on every cycle. They check that each acknowledge decision and each transmit byte follows its triggering event by one cycle, that the two strobes never coincide, that a foreign address always gets a NACK, and that the register outputs change only in a cycle after a received data byte. Some behaviour can only be shown by the bench's scenarios, because it needs whole transactions: pointer wrap, the count byte in both directions, the FFh padding after a block read, the reserved and read-only map, the end of a read on master NACK, and aborts by stop or repeated start.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WR, ST_RD
  } xfer_st_e;

  localparam int unsigned CMD_BLK_BIT = 4;
  localparam int unsigned NUM_RW      = 7;   // indices 0..6 writable
  localparam int unsigned IDX_TIMING  = 1;
  localparam logic [3:0]  IDX_ID      = 4'hA;
  localparam logic [3:0]  IDX_CH0_LO  = 4'hC;
  localparam logic [3:0]  IDX_CH0_HI  = 4'hD;
  localparam logic [3:0]  IDX_CH1_LO  = 4'hE;
  localparam logic [3:0]  IDX_CH1_HI  = 4'hF;
endpackage

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_reg_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 4,
  parameter logic [7:0]  TIMING_RST = 8'h02,
  parameter logic [7:0]  ID_VAL     = 8'h50
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [AW-1:0]   raddr_i,
  input  logic [2*DW-1:0] ch0_i,
  input  logic [2*DW-1:0] ch1_i,
  output logic [DW-1:0]   ctrl_o,
  output logic [DW-1:0]   timing_o,
  output logic [2*DW-1:0] thr_low_o,
  output logic [2*DW-1:0] thr_high_o,
  output logic [DW-1:0]   int_ctrl_o,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] rw_q [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    localparam logic [DW-1:0] RST_V = (g == IDX_TIMING) ? DW'(TIMING_RST) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           rw_q[g] <= RST_V;
      else if (we_i && waddr_i == AW'(g))    rw_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      IDX_ID:     rdata_o = DW'(ID_VAL);
      IDX_CH0_LO: rdata_o = ch0_i[DW-1:0];
      IDX_CH0_HI: rdata_o = ch0_i[2*DW-1:DW];
      IDX_CH1_LO: rdata_o = ch1_i[DW-1:0];
      IDX_CH1_HI: rdata_o = ch1_i[2*DW-1:DW];
      default: begin
        for (int i = 0; i < NUM_RW; i++)
          if (raddr_i == AW'(i)) rdata_o = rw_q[i];
      end
    endcase
  end

  assign ctrl_o     = rw_q[0];
  assign timing_o   = rw_q[1];
  assign thr_low_o  = {rw_q[3], rw_q[2]};
  assign thr_high_o = {rw_q[5], rw_q[4]};
  assign int_ctrl_o = rw_q[6];
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_reg_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 4,
  parameter int unsigned SAW        = 7,
  parameter logic [7:0]  BLK_RD_CNT = 8'd2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SAW-1:0] own_addr_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_vld_i,
  input  logic [SAW:0]  addr_i,
  input  logic          wr_vld_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_req_i,
  input  logic          mnack_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          ack_vld_o,
  output logic          ack_o,
  output logic          tx_vld_o,
  output logic [DW-1:0] tx_data_o
);
  xfer_st_e      st_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] cnt_q;
  logic          blk_q, cnt_pend_q;
  logic          bus_evt, wr_take;

  assign bus_evt = start_i | stop_i;
  // block-mode writes stop once the count is used up
  assign wr_take = wr_vld_i && !bus_evt && st_q == ST_WR && (!blk_q || cnt_q != '0);
  assign we_o    = wr_take;
  assign wdata_o = wr_data_i;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      cnt_q      <= '0;
      blk_q      <= 1'b0;
      cnt_pend_q <= 1'b0;
      ack_vld_o  <= 1'b0;
      ack_o      <= 1'b0;
      tx_vld_o   <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      ack_vld_o <= 1'b0;
      tx_vld_o  <= 1'b0;
      if (stop_i) st_q <= ST_IDLE;
      else if (start_i) st_q <= ST_ADDR;
      else begin
        unique case (st_q)
          ST_ADDR: if (addr_vld_i) begin
            ack_vld_o <= 1'b1;
            if (addr_i[SAW:1] == own_addr_i) begin
              ack_o      <= 1'b1;
              st_q       <= addr_i[0] ? ST_RD : ST_CMD;
              cnt_pend_q <= blk_q;
            end else begin
              ack_o <= 1'b0;
              st_q  <= ST_IDLE;
            end
          end
          ST_CMD: if (wr_vld_i) begin
            ack_vld_o <= 1'b1;
            ack_o     <= 1'b1;
            ptr_q     <= wr_data_i[AW-1:0];
            blk_q     <= wr_data_i[CMD_BLK_BIT];
            st_q      <= wr_data_i[CMD_BLK_BIT] ? ST_CNT : ST_WR;
          end
          ST_CNT: if (wr_vld_i) begin
            ack_vld_o <= 1'b1;
            ack_o     <= 1'b1;
            cnt_q     <= wr_data_i;
            st_q      <= ST_WR;
          end
          ST_WR: if (wr_vld_i) begin
            ack_vld_o <= 1'b1;
            ack_o     <= wr_take;
            if (wr_take) begin
              ptr_q <= ptr_q + 1'b1;
              if (blk_q) cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_RD: begin
            if (mnack_i) st_q <= ST_IDLE;
            else if (rd_req_i) begin
              tx_vld_o <= 1'b1;
              if (cnt_pend_q) begin
                tx_data_o  <= DW'(BLK_RD_CNT);
                cnt_q      <= DW'(BLK_RD_CNT);
                cnt_pend_q <= 1'b0;
              end else if (blk_q && cnt_q == '0) begin
                tx_data_o <= '1;
              end else begin
                tx_data_o <= rdata_i;
                ptr_q     <= ptr_q + 1'b1;
                if (blk_q) cnt_q <= cnt_q - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_reg_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 4,
  parameter int unsigned SAW        = 7,
  parameter logic [7:0]  TIMING_RST = 8'h02,
  parameter logic [7:0]  ID_VAL     = 8'h50,
  parameter logic [7:0]  BLK_RD_CNT = 8'd2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SAW-1:0]  own_addr_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            addr_vld_i,
  input  logic [SAW:0]    addr_i,
  input  logic            wr_vld_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_req_i,
  input  logic            mnack_i,
  input  logic [2*DW-1:0] ch0_i,
  input  logic [2*DW-1:0] ch1_i,
  output logic            ack_vld_o,
  output logic            ack_o,
  output logic            tx_vld_o,
  output logic [DW-1:0]   tx_data_o,
  output logic [DW-1:0]   ctrl_o,
  output logic [DW-1:0]   timing_o,
  output logic [2*DW-1:0] thr_low_o,
  output logic [2*DW-1:0] thr_high_o,
  output logic [DW-1:0]   int_ctrl_o
);
  logic [AW-1:0] ptr;
  logic          we;
  logic [DW-1:0] wdata, rdata;

  smb_xfer_fsm #(.DW(DW), .AW(AW), .SAW(SAW), .BLK_RD_CNT(BLK_RD_CNT)) u_fsm (
    .clk_i, .rst_ni, .own_addr_i, .start_i, .stop_i, .addr_vld_i, .addr_i,
    .wr_vld_i, .wr_data_i, .rd_req_i, .mnack_i,
    .rdata_i(rdata), .ptr_o(ptr), .we_o(we), .wdata_o(wdata),
    .ack_vld_o, .ack_o, .tx_vld_o, .tx_data_o
  );

  smb_reg_bank #(.DW(DW), .AW(AW), .TIMING_RST(TIMING_RST), .ID_VAL(ID_VAL)) u_bank (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(ptr), .wdata_i(wdata), .raddr_i(ptr),
    .ch0_i, .ch1_i, .ctrl_o, .timing_o, .thr_low_o, .thr_high_o, .int_ctrl_o,
    .rdata_o(rdata)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned SAW = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [SAW-1:0]  own_addr_i,
  input logic            addr_vld_i,
  input logic [SAW:0]    addr_i,
  input logic            wr_vld_i,
  input logic            rd_req_i,
  input logic            ack_vld_o,
  input logic            ack_o,
  input logic            tx_vld_o,
  input logic [DW-1:0]   ctrl_o,
  input logic [DW-1:0]   timing_o,
  input logic [2*DW-1:0] thr_low_o,
  input logic [2*DW-1:0] thr_high_o,
  input logic [DW-1:0]   int_ctrl_o
);
  assert_ack_follows_byte_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(addr_vld_i || wr_vld_i));

  assert_tx_follows_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(rd_req_i));

  assert_strobes_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_vld_o && tx_vld_o));

  assert_foreign_addr_nack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && $past(addr_vld_i) && !$past(wr_vld_i)
     && $past(addr_i[SAW:1]) != $past(own_addr_i)) |-> !ack_o);

  assert_regs_need_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_vld_i) |-> $stable({ctrl_o, timing_o, thr_low_o, thr_high_o, int_ctrl_o}));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.DW(DW), .SAW(SAW)) u_chk (.*);

// File: tb/sim_smb_reg_slave.sv
module sim_smb_reg_slave;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [6:0]  own_addr = 7'h39;
  logic        start = 0, stop = 0, addr_vld = 0, wr_vld = 0, rd_req = 0, mnack = 0;
  logic [7:0]  addr = 0, wr_data = 0;
  logic [15:0] ch0 = 16'hC0DE, ch1 = 16'h1234;
  logic        ack_vld, ack, tx_vld;
  logic [7:0]  tx_data, ctrl, timing, int_ctrl;
  logic [15:0] thr_low, thr_high;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  smb_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(own_addr), .start_i(start), .stop_i(stop),
    .addr_vld_i(addr_vld), .addr_i(addr), .wr_vld_i(wr_vld), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .mnack_i(mnack), .ch0_i(ch0), .ch1_i(ch1),
    .ack_vld_o(ack_vld), .ack_o(ack), .tx_vld_o(tx_vld), .tx_data_o(tx_data),
    .ctrl_o(ctrl), .timing_o(timing), .thr_low_o(thr_low), .thr_high_o(thr_high),
    .int_ctrl_o(int_ctrl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic ev_stop();
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
  endtask

  task automatic send_addr(input logic [6:0] a, input bit rd, input bit exp_ack, input string tag);
    @(negedge clk) begin addr_vld = 1; addr = {a, rd}; end
    @(negedge clk) addr_vld = 0;
    chk(ack_vld === 1'b1, {tag, " addr ack_vld"}, int'(ack_vld), 1);
    chk(ack === exp_ack, {tag, " addr ack"}, int'(ack), int'(exp_ack));
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_vld, input bit exp_ack, input string tag);
    @(negedge clk) begin wr_vld = 1; wr_data = d; end
    @(negedge clk) wr_vld = 0;
    chk(ack_vld === exp_vld, {tag, " byte ack_vld"}, int'(ack_vld), int'(exp_vld));
    if (exp_vld) chk(ack === exp_ack, {tag, " byte ack"}, int'(ack), int'(exp_ack));
  endtask

  task automatic read_byte(input bit exp_vld, input logic [7:0] exp_d, input string tag);
    @(negedge clk) rd_req = 1;
    @(negedge clk) rd_req = 0;
    chk(tx_vld === exp_vld, {tag, " tx_vld"}, int'(tx_vld), int'(exp_vld));
    if (exp_vld) chk(tx_data === exp_d, {tag, " tx_data"}, int'(tx_data), int'(exp_d));
  endtask

  task automatic t_reset();
    chk(ctrl === 8'h00 && int_ctrl === 8'h00, "R1 ctrl/int", int'(ctrl), 0);
    chk(timing === 8'h02, "R1 timing", int'(timing), 2);
    chk(thr_low === 16'h0 && thr_high === 16'h0, "R1 thresholds", int'(thr_low), 0);
    chk(!ack_vld && !tx_vld, "R1 strobes idle", int'({ack_vld, tx_vld}), 0);
  endtask

  task automatic t_stream_write();
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h00, 1, 1, "R3 cmd");
    send_byte(8'h11, 1, 1, "R4"); send_byte(8'h22, 1, 1, "R4");
    ev_stop();
    chk(ctrl === 8'h11, "R4 ctrl", int'(ctrl), 'h11);
    chk(timing === 8'h22, "R4 timing", int'(timing), 'h22);
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h0F, 1, 1, "R3 cmd");
    send_byte(8'hAA, 1, 1, "R8 write to Fh acked");
    send_byte(8'hBB, 1, 1, "R4 wrap");
    ev_stop();
    chk(ctrl === 8'hBB, "R4 wrap to 0h", int'(ctrl), 'hBB);
    chk(timing === 8'h22 && thr_low === 16'h0, "R8 Fh write ignored", int'(timing), 'h22);
  endtask

  task automatic t_stream_read();
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h0E, 1, 1, "R3 cmd");
    ev_start(); send_addr(7'h39, 1, 1, "R10 rstart");
    read_byte(1, 8'h34, "R8 ch1 lo");
    read_byte(1, 8'h12, "R8 ch1 hi");
    read_byte(1, 8'hBB, "R6 wrap ctrl");
    read_byte(1, 8'h22, "R6 timing");
    @(negedge clk) mnack = 1;
    @(negedge clk) mnack = 0;
    read_byte(0, 8'h00, "R9 after nack");
    ev_stop();
  endtask

  task automatic t_block_write();
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h12, 1, 1, "R3 blk cmd");
    send_byte(8'h03, 1, 1, "R5 count");
    send_byte(8'h01, 1, 1, "R5"); send_byte(8'h02, 1, 1, "R5"); send_byte(8'h03, 1, 1, "R5");
    send_byte(8'h04, 1, 0, "R5 beyond count");
    ev_stop();
    chk(thr_low === 16'h0201, "R5 thr_low", int'(thr_low), 'h0201);
    chk(thr_high === 16'h0003, "R5 extra not stored", int'(thr_high), 'h0003);
  endtask

  task automatic t_abort();
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h14, 1, 1, "R3"); send_byte(8'h03, 1, 1, "R5 count");
    send_byte(8'h44, 1, 1, "R10");
    ev_stop();
    send_byte(8'h55, 0, 0, "R10 after stop");
    chk(thr_high === 16'h0044, "R10 stop abort", int'(thr_high), 'h0044);
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h16, 1, 1, "R3"); send_byte(8'h02, 1, 1, "R5 count");
    send_byte(8'h66, 1, 1, "R10");
    ev_start();
    send_byte(8'h77, 0, 0, "R10 after rstart");
    ev_stop();
    chk(int_ctrl === 8'h66, "R10 rstart abort", int'(int_ctrl), 'h66);
    chk(thr_high === 16'h0044, "R10 thr_high kept", int'(thr_high), 'h0044);
  endtask

  task automatic t_block_read();
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h1A, 1, 1, "R3 blk cmd");
    ev_start(); send_addr(7'h39, 1, 1, "R2");
    read_byte(1, 8'h02, "R7 count");
    read_byte(1, 8'h50, "R8 id");
    read_byte(1, 8'h00, "R8 Bh reserved");
    read_byte(1, 8'hFF, "R7 pad");
    read_byte(1, 8'hFF, "R7 pad again");
    ev_stop();
  endtask

  task automatic t_reserved();
    ev_start(); send_addr(7'h39, 0, 1, "R2");
    send_byte(8'h07, 1, 1, "R3");
    ev_start(); send_addr(7'h39, 1, 1, "R2");
    read_byte(1, 8'h00, "R8 7h");
    read_byte(1, 8'h00, "R8 8h");
    read_byte(1, 8'h00, "R8 9h");
    read_byte(1, 8'h50, "R6 Ah after 9h");
    @(negedge clk) mnack = 1;
    @(negedge clk) mnack = 0;
    ev_stop();
  endtask

  task automatic t_foreign();
    ev_start(); send_addr(7'h3A, 0, 0, "R2 foreign write");
    send_byte(8'h99, 0, 0, "R2 ignored byte");
    ev_stop();
    chk(ctrl === 8'hBB, "R2 ctrl untouched", int'(ctrl), 'hBB);
    ev_start(); send_addr(7'h38, 1, 0, "R2 foreign read");
    read_byte(0, 8'h00, "R2 no tx");
    ev_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stream_write();
    t_stream_read();
    t_block_write();
    t_abort();
    t_block_read();
    t_reserved();
    t_foreign();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule